// File: doc/BRIEF.md
# Frame DMA channel control and interrupt register unit

This block is the software-facing register unit of an eight-channel frame DMA engine. A host reaches it over a plain 32-bit register bus with word addresses. Writes are taken on the clock edge where `bus_en` and `bus_wr` are both high. Read data is combinational from the address. The unit stores per-channel configuration words and 64-bit first-descriptor pointers, and it drives both to the channel datapaths. It also holds the two direction stop bits.

Four command addresses take a one-bit-per-channel mask. Each 1 in the mask becomes a single-cycle strobe to that channel: start, reload, disable or discard of buffers. The unit keeps an active flag for each channel. A disable does not clear the flag at once. The flag is cleared only once the channel reports that it is idle, so software can poll the active register until the channel has drained.

Block-done and error events from the datapaths are latched into status registers that are cleared by writing ones. The done bits pass through an enable mask. The done bits and the error bits together drive one interrupt line.

Top module: `dmac_chan_ctrl`

## Requirements
- R1: After reset the following all read zero: the active register, the done status register, the done enable register, the error status register, the error type register, every configuration word and every pointer word. `irq_o` is 0. The port control register reads 0x14, which means both stop bits are set, and `xtr_stop_o` and `inj_stop_o` are 1.
- R2: A write of mask M to one of the command addresses drives the matching strobe output for exactly the one cycle after the write edge. The addresses are start 0x00, reload 0x01, disable 0x02 and discard 0x03. The strobe value is M, except for reload (see R5). The strobe is zero again in the following cycle if no new command is written.
- R3: Reads of command addresses 0x00 to 0x03 always return zero.
- R4: A start command sets the channel's bit in the active register at 0x04. A disable sent to an active channel leaves the bit set while `ch_idle_i` for that channel is 0. The bit clears on the first edge at which the channel is draining and its idle input is 1.
- R5: A reload command is ignored for a channel that is not active. No reload strobe is issued for it and its active bit does not change. Active channels in the same mask do get the strobe.
- R6: The configuration word of channel n is at 0x10+n and is 5 bits wide: bit 0 memory mode, bits 2:1 data blocks per control block, bit 3 injection port select, bit 4 interrupt on end of frame only. Upper bits read as zero. The word appears on `cfg_o[5n+4:5n]`.
- R7: The low half of channel n's first-descriptor pointer is at 0x20+n and the high half is at 0x28+n. Both read back as written. `desc_ptr_o[64n+63:64n]` carries {high, low}.
- R8: The done status register at 0x05 sets bit n when `done_evt_i[n]` is 1 on an edge. A write of ones to 0x05 clears those bits. An event arriving on the same edge as a clear wins.
- R9: `irq_o` is 1 exactly when some channel has both its done status bit and its enable bit set (enable register at 0x06, 8 bits), or when any error status bit is set.
- R10: The error status register at 0x07 latches `err_evt_i` per channel. The error type register at 0x08 ORs in `err_type_i` on each edge where any error event is present. Both are cleared by writing back the value that was read.
- R11: The port control register at 0x09 holds the extraction stop bit at bit 2 and the injection stop bit at bit 4. It drives `xtr_stop_o` and `inj_stop_o`. All other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| ch_idle_i | input | 8 | Per-channel idle indication from the datapaths |
| done_evt_i | input | 8 | Per-channel block-done event |
| err_evt_i | input | 8 | Per-channel error event |
| err_type_i | input | 8 | Error type bits, captured with any error event |
| start_stb_o | output | 8 | Start strobes |
| reload_stb_o | output | 8 | Reload strobes (active channels only) |
| disable_stb_o | output | 8 | Disable strobes |
| discard_stb_o | output | 8 | Buffer discard strobes |
| cfg_o | output | 40 | Per-channel configuration words, 5 bits each |
| desc_ptr_o | output | 512 | Per-channel 64-bit first-descriptor pointers |
| xtr_stop_o | output | 1 | Extraction direction stop |
| inj_stop_o | output | 1 | Injection direction stop |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check the following on every cycle:
- Strobes fall silent in any cycle that follows an edge with no command write.
- No reload strobe reaches a channel that was inactive.
- An active bit rises only after a start command for that channel, and falls only after that channel was draining and reported idle.
- A status bit sets only when its event is present, and clears only when a one is written to that bit.
- The stop bits stay put without a write.

Some behaviours only the bench's scenarios can show:
- The exact strobe values and their single-cycle timing.
- That a disabled channel holds its active bit through several busy cycles.
- The field masking of the configuration words.
- That a pointer reaches the right output slice.
- The interrupt gating through the enable mask.
- That an event beats a clear arriving on the same edge.

// File: rtl/dmac_chan_pkg.sv
package dmac_chan_pkg;
  localparam int CFG_W  = 5;
  localparam int PTR_W  = 32;

  localparam logic [7:0] A_START   = 8'h00;
  localparam logic [7:0] A_RELOAD  = 8'h01;
  localparam logic [7:0] A_DISABLE = 8'h02;
  localparam logic [7:0] A_DISCARD = 8'h03;
  localparam logic [7:0] A_ACTIVE  = 8'h04;
  localparam logic [7:0] A_DONE    = 8'h05;
  localparam logic [7:0] A_DONE_EN = 8'h06;
  localparam logic [7:0] A_ERR     = 8'h07;
  localparam logic [7:0] A_ERRTYPE = 8'h08;
  localparam logic [7:0] A_PORT    = 8'h09;
  localparam logic [4:0] G_CFG     = 5'h02;  // 0x10..0x17
  localparam logic [4:0] G_PLO     = 5'h04;  // 0x20..0x27
  localparam logic [4:0] G_PHI     = 5'h05;  // 0x28..0x2F

  localparam int XTR_BIT = 2;
  localparam int INJ_BIT = 4;

  typedef struct packed {
    logic       eof_irq_only;
    logic       inj_port;
    logic [1:0] blk_cnt;
    logic       mem_mode;
  } chan_cfg_t;
endpackage

// File: rtl/dmac_cmd_unit.sv
module dmac_cmd_unit #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we_start,
  input  logic           we_reload,
  input  logic           we_disable,
  input  logic           we_discard,
  input  logic [NCH-1:0] wmask,
  input  logic [NCH-1:0] idle_i,
  output logic [NCH-1:0] start_o,
  output logic [NCH-1:0] reload_o,
  output logic [NCH-1:0] disable_o,
  output logic [NCH-1:0] discard_o,
  output logic [NCH-1:0] active_o
);
  logic [NCH-1:0] start_q, reload_q, disable_q, discard_q;
  logic [NCH-1:0] start_d, reload_d, disable_d, discard_d;
  logic [NCH-1:0] active_q, active_d, drain_q, drain_d;

  always_comb begin
    start_d   = we_start   ? wmask : '0;
    reload_d  = we_reload  ? (wmask & active_q) : '0;
    disable_d = we_disable ? wmask : '0;
    discard_d = we_discard ? wmask : '0;
    active_d  = active_q;
    drain_d   = drain_q;
    for (int i = 0; i < NCH; i++) begin
      if (start_d[i]) begin
        active_d[i] = 1'b1;
        drain_d[i]  = 1'b0;
      end else if (disable_d[i] && active_q[i]) begin
        drain_d[i]  = 1'b1;
      end else if (drain_q[i] && idle_i[i]) begin
        active_d[i] = 1'b0;
        drain_d[i]  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q   <= '0;
      reload_q  <= '0;
      disable_q <= '0;
      discard_q <= '0;
      active_q  <= '0;
      drain_q   <= '0;
    end else begin
      start_q   <= start_d;
      reload_q  <= reload_d;
      disable_q <= disable_d;
      discard_q <= discard_d;
      active_q  <= active_d;
      drain_q   <= drain_d;
    end
  end

  assign start_o   = start_q;
  assign reload_o  = reload_q;
  assign disable_o = disable_q;
  assign discard_o = discard_q;
  assign active_o  = active_q;

  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_start || we_reload || we_disable || we_discard) |=> ((start_q | reload_q | disable_q | discard_q) == '0)); // R2
  AST_RELOAD_ACTIVE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_q & ~$past(active_q)) == '0); // R5

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    AST_ACTIVE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active_q[g]) |-> $past(we_start && wmask[g])); // R4
    AST_ACTIVE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(active_q[g]) |-> $past(drain_q[g] && idle_i[g])); // R4
  end
endmodule

// File: rtl/dmac_evt_stat.sv
module dmac_evt_stat #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_we,
  input  logic [W-1:0] clr_data,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] stat_q, stat_d, clr_mask;

  always_comb begin
    clr_mask = clr_we ? clr_data : '0;
    stat_d   = (stat_q & ~clr_mask) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign stat_o = stat_q;

  AST_STAT_SET_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q & ~$past(stat_q) & ~$past(set_i)) == '0); // R8
  AST_STAT_CLR_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (~stat_q & $past(stat_q) & ~($past(clr_we) ? $past(clr_data) : '0)) == '0); // R10
endmodule

// File: rtl/dmac_cfg_regs.sv
module dmac_cfg_regs #(
  parameter int NCH   = 8,
  parameter int CFG_W = 5,
  parameter int PTR_W = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NCH-1:0]            we_cfg,
  input  logic [NCH-1:0]            we_lo,
  input  logic [NCH-1:0]            we_hi,
  input  logic                      we_en,
  input  logic                      we_port,
  input  logic [PTR_W-1:0]          wdata,
  output logic [NCH-1:0][CFG_W-1:0] cfg_o,
  output logic [NCH-1:0][PTR_W-1:0] lo_o,
  output logic [NCH-1:0][PTR_W-1:0] hi_o,
  output logic [NCH-1:0]            en_o,
  output logic                      xtr_stop_o,
  output logic                      inj_stop_o
);
  import dmac_chan_pkg::*;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_o[g] <= '0;
        lo_o[g]  <= '0;
        hi_o[g]  <= '0;
      end else begin
        if (we_cfg[g]) cfg_o[g] <= wdata[CFG_W-1:0];
        if (we_lo[g])  lo_o[g]  <= wdata;
        if (we_hi[g])  hi_o[g]  <= wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_o       <= '0;
      xtr_stop_o <= 1'b1;
      inj_stop_o <= 1'b1;
    end else begin
      if (we_en) en_o <= wdata[NCH-1:0];
      if (we_port) begin
        xtr_stop_o <= wdata[XTR_BIT];
        inj_stop_o <= wdata[INJ_BIT];
      end
    end
  end

  AST_PORT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !we_port |=> $stable({xtr_stop_o, inj_stop_o})); // R11
endmodule

// File: rtl/dmac_chan_ctrl.sv
module dmac_chan_ctrl #(
  parameter int NCH    = 8,
  parameter int TYPE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_en,
  input  logic                bus_wr,
  input  logic [7:0]          bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NCH-1:0]      ch_idle_i,
  input  logic [NCH-1:0]      done_evt_i,
  input  logic [NCH-1:0]      err_evt_i,
  input  logic [TYPE_W-1:0]   err_type_i,
  output logic [NCH-1:0]      start_stb_o,
  output logic [NCH-1:0]      reload_stb_o,
  output logic [NCH-1:0]      disable_stb_o,
  output logic [NCH-1:0]      discard_stb_o,
  output logic [NCH*5-1:0]    cfg_o,
  output logic [NCH*64-1:0]   desc_ptr_o,
  output logic                xtr_stop_o,
  output logic                inj_stop_o,
  output logic                irq_o
);
  import dmac_chan_pkg::*;

  logic                      wr;
  logic [NCH-1:0]            we_cfg, we_lo, we_hi;
  logic [NCH-1:0]            active, done_q, err_q, en_q;
  logic [TYPE_W-1:0]         type_q, type_set;
  logic [NCH-1:0][CFG_W-1:0] cfg_q;
  logic [NCH-1:0][PTR_W-1:0] lo_q, hi_q;

  assign wr = bus_en && bus_wr;

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      we_cfg[i] = wr && (bus_addr == {G_CFG, 3'(i)});
      we_lo[i]  = wr && (bus_addr == {G_PLO, 3'(i)});
      we_hi[i]  = wr && (bus_addr == {G_PHI, 3'(i)});
    end
  end

  dmac_cmd_unit #(.NCH(NCH)) u_cmd (
    .clk        (clk),
    .rst_n      (rst_n),
    .we_start   (wr && bus_addr == A_START),
    .we_reload  (wr && bus_addr == A_RELOAD),
    .we_disable (wr && bus_addr == A_DISABLE),
    .we_discard (wr && bus_addr == A_DISCARD),
    .wmask      (bus_wdata[NCH-1:0]),
    .idle_i     (ch_idle_i),
    .start_o    (start_stb_o),
    .reload_o   (reload_stb_o),
    .disable_o  (disable_stb_o),
    .discard_o  (discard_stb_o),
    .active_o   (active)
  );

  dmac_evt_stat #(.W(NCH)) u_done (
    .clk (clk), .rst_n (rst_n), .set_i (done_evt_i),
    .clr_we (wr && bus_addr == A_DONE), .clr_data (bus_wdata[NCH-1:0]),
    .stat_o (done_q)
  );

  dmac_evt_stat #(.W(NCH)) u_err (
    .clk (clk), .rst_n (rst_n), .set_i (err_evt_i),
    .clr_we (wr && bus_addr == A_ERR), .clr_data (bus_wdata[NCH-1:0]),
    .stat_o (err_q)
  );

  assign type_set = err_type_i & {TYPE_W{|err_evt_i}};

  dmac_evt_stat #(.W(TYPE_W)) u_type (
    .clk (clk), .rst_n (rst_n), .set_i (type_set),
    .clr_we (wr && bus_addr == A_ERRTYPE), .clr_data (bus_wdata[TYPE_W-1:0]),
    .stat_o (type_q)
  );

  dmac_cfg_regs #(.NCH(NCH), .CFG_W(CFG_W), .PTR_W(PTR_W)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .we_cfg     (we_cfg),
    .we_lo      (we_lo),
    .we_hi      (we_hi),
    .we_en      (wr && bus_addr == A_DONE_EN),
    .we_port    (wr && bus_addr == A_PORT),
    .wdata      (bus_wdata),
    .cfg_o      (cfg_q),
    .lo_o       (lo_q),
    .hi_o       (hi_q),
    .en_o       (en_q),
    .xtr_stop_o (xtr_stop_o),
    .inj_stop_o (inj_stop_o)
  );

  assign cfg_o = cfg_q;
  for (genvar g = 0; g < NCH; g++) begin : g_ptr
    assign desc_ptr_o[g*64 +: 64] = {hi_q[g], lo_q[g]};
  end

  assign irq_o = (|(done_q & en_q)) || (|err_q);

  always_comb begin
    bus_rdata = '0;
    if      (bus_addr == A_ACTIVE)  bus_rdata[NCH-1:0]    = active;
    else if (bus_addr == A_DONE)    bus_rdata[NCH-1:0]    = done_q;
    else if (bus_addr == A_DONE_EN) bus_rdata[NCH-1:0]    = en_q;
    else if (bus_addr == A_ERR)     bus_rdata[NCH-1:0]    = err_q;
    else if (bus_addr == A_ERRTYPE) bus_rdata[TYPE_W-1:0] = type_q;
    else if (bus_addr == A_PORT) begin
      bus_rdata[XTR_BIT] = xtr_stop_o;
      bus_rdata[INJ_BIT] = inj_stop_o;
    end
    else if (bus_addr[7:3] == G_CFG) bus_rdata[CFG_W-1:0] = cfg_q[bus_addr[2:0]];
    else if (bus_addr[7:3] == G_PLO) bus_rdata = lo_q[bus_addr[2:0]];
    else if (bus_addr[7:3] == G_PHI) bus_rdata = hi_q[bus_addr[2:0]];
  end

  AST_IRQ_QUIET_WHEN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(done_q) == '0 && $past(err_q) == '0 && done_evt_i == '0 && err_evt_i == '0
     && $past(done_evt_i) == '0 && $past(err_evt_i) == '0) |-> !irq_o); // R9
endmodule

// File: tb/dmac_chan_ctrl_test.sv
module dmac_chan_ctrl_test;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         bus_en, bus_wr;
  logic [7:0]   bus_addr;
  logic [31:0]  bus_wdata, bus_rdata;
  logic [7:0]   ch_idle_i, done_evt_i, err_evt_i, err_type_i;
  logic [7:0]   start_stb_o, reload_stb_o, disable_stb_o, discard_stb_o;
  logic [39:0]  cfg_o;
  logic [511:0] desc_ptr_o;
  logic         xtr_stop_o, inj_stop_o, irq_o;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dmac_chan_ctrl uut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bwrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1;
    bus_en = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bread(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    bread(8'h04, d); chk("R1 active", d, 0);
    bread(8'h05, d); chk("R1 done", d, 0);
    bread(8'h06, d); chk("R1 enable", d, 0);
    bread(8'h08, d); chk("R1 errtype", d, 0);
    bread(8'h09, d); chk("R1 port", d, 32'h14);
    bread(8'h13, d); chk("R1 cfg3", d, 0);
    bread(8'h2C, d); chk("R1 ptr hi4", d, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 stops", {xtr_stop_o, inj_stop_o}, 2'b11);
  endtask

  task automatic t_start();
    logic [31:0] d;
    bwrite(8'h00, 32'h09);
    chk("R2 start strobe", start_stb_o, 8'h09);
    @(posedge clk); #1;
    chk("R2 start strobe gone", start_stb_o, 8'h00);
    bread(8'h04, d); chk("R4 active after start", d, 32'h09);
    bread(8'h00, d); chk("R3 start reads zero", d, 0);
    bread(8'h02, d); chk("R3 disable reads zero", d, 0);
  endtask

  task automatic t_reload();
    logic [31:0] d;
    bwrite(8'h01, 32'h03);
    chk("R5 reload only active", reload_stb_o, 8'h01);
    @(posedge clk); #1;
    chk("R2 reload strobe gone", reload_stb_o, 8'h00);
    bread(8'h04, d); chk("R5 active unchanged", d, 32'h09);
  endtask

  task automatic t_disable();
    logic [31:0] d;
    bwrite(8'h02, 32'h08);
    chk("R2 disable strobe", disable_stb_o, 8'h08);
    repeat (3) @(posedge clk);
    bread(8'h04, d); chk("R4 active held while busy", d, 32'h09);
    @(negedge clk); ch_idle_i = 8'h08;
    @(posedge clk); #1;
    bread(8'h04, d); chk("R4 active cleared when idle", d, 32'h01);
    ch_idle_i = 8'h00;
    bwrite(8'h03, 32'h80);
    chk("R2 discard strobe", discard_stb_o, 8'h80);
  endtask

  task automatic t_cfg();
    logic [31:0] d;
    bwrite(8'h15, 32'hFFFF_FFFF);
    bread(8'h15, d); chk("R6 cfg5 masked", d, 32'h1F);
    chk("R6 cfg5 output", cfg_o[25 +: 5], 5'h1F);
    bwrite(8'h12, 32'h0000_000B);
    bread(8'h12, d); chk("R6 cfg2 readback", d, 32'h0B);
    chk("R6 cfg2 fields mem/cnt/inj/eof", {cfg_o[14], cfg_o[13], cfg_o[12:11], cfg_o[10]}, 5'b0_1_01_1);
  endtask

  task automatic t_ptr();
    logic [31:0] d;
    bwrite(8'h27, 32'hDEAD_BEEF);
    bwrite(8'h2F, 32'h1234_5678);
    bread(8'h27, d); chk("R7 ptr lo7", d, 32'hDEAD_BEEF);
    bread(8'h2F, d); chk("R7 ptr hi7", d, 32'h1234_5678);
    chk("R7 ptr7 output", desc_ptr_o[448 +: 64], 64'h1234_5678_DEAD_BEEF);
  endtask

  task automatic t_done();
    logic [31:0] d;
    @(negedge clk); done_evt_i = 8'h24;
    @(negedge clk); done_evt_i = 8'h00;
    bread(8'h05, d); chk("R8 done latched", d, 32'h24);
    chk("R9 irq masked", irq_o, 0);
    bwrite(8'h06, 32'h04);
    chk("R9 irq enabled", irq_o, 1);
    bwrite(8'h05, 32'h04);
    bread(8'h05, d); chk("R8 done w1c", d, 32'h20);
    chk("R9 irq after clear", irq_o, 0);
    @(negedge clk); done_evt_i = 8'h02;
    bwrite(8'h05, 32'h02);
    done_evt_i = 8'h00;
    bread(8'h05, d); chk("R8 event beats clear", d, 32'h22);
    bwrite(8'h05, 32'hFF);
    bread(8'h05, d); chk("R8 done cleared", d, 0);
  endtask

  task automatic t_err();
    logic [31:0] d;
    @(negedge clk); err_evt_i = 8'h40; err_type_i = 8'h05;
    @(negedge clk); err_evt_i = 8'h00; err_type_i = 8'hF0;
    @(negedge clk);
    bread(8'h07, d); chk("R10 err latched", d, 32'h40);
    bread(8'h08, d); chk("R10 type latched", d, 32'h05);
    chk("R9 irq on error", irq_o, 1);
    bwrite(8'h07, 32'h40);
    bwrite(8'h08, 32'h05);
    bread(8'h07, d); chk("R10 err cleared", d, 0);
    bread(8'h08, d); chk("R10 type cleared", d, 0);
    chk("R9 irq gone", irq_o, 0);
  endtask

  task automatic t_port();
    logic [31:0] d;
    bwrite(8'h09, 32'h0000_0010);
    bread(8'h09, d); chk("R11 port inj only", d, 32'h10);
    chk("R11 stop outputs", {xtr_stop_o, inj_stop_o}, 2'b01);
    bwrite(8'h09, 32'hFFFF_FFFF);
    bread(8'h09, d); chk("R11 port masked", d, 32'h14);
  endtask

  initial begin
    #500000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_en = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    ch_idle_i = '0; done_evt_i = '0; err_evt_i = '0; err_type_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_start();
    t_reload();
    t_disable();
    t_cfg();
    t_ptr();
    t_done();
    t_err();
    t_port();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule